// File: doc/BRIEF.md
# SMBus Client with Alert Response Handling

This block is the SMBus client interface of a monitoring chip. It watches sampled SCL and SDA, finds START and STOP conditions, and decodes the address byte and the read/write bit. When it answers, it pulls SDA low through an open-drain enable. SDA is used both for acknowledge bits and for the data bits the block sends. Byte writes and byte reads pass to a register file through a plain strobe port. An internal pointer holds the command byte, so a read can use a repeated START or a receive-byte access. The block itself holds two registers: a sticky status register that clears when read, and a configuration register whose top bit is the alert mask.

The block also controls the active-high alert request. An event raises the request while the pin is in interrupt mode and the mask is clear. A host then reads the Alert Response Address. The block answers only while its alert is actually asserted, and it replies with its own address. The block watches its own transmission for lost arbitration. After a clean reply, it sets the mask and drops the alert, but only if the status register has already been read empty.

An inactivity counter runs on a clock-enable tick. It sends the protocol engine back to idle when the bus has been quiet for a programmable number of ticks.

Top module: `smb_alert_client`

## Requirements
- R1: The block acknowledges the address byte only for 7-bit address 0x4C (write byte 0x98, read byte 0x99). Any other address gets no ACK on the address byte or on any later byte, and produces no register write strobe.
- R2: The write sequence START, 0x98, command, data, STOP produces exactly one write strobe, with the command as address and the data byte as data. A further byte in the same write is not acknowledged and produces no strobe.
- R3: A read (START, 0x98, command, repeated START, 0x99) returns the byte at the command offset, most significant bit first. A read of offset 0x02 returns the status register and then clears it.
- R4: If no SCL or SDA edge occurs for TIMEOUT_TICKS ticks, the interface returns to idle. The partial transaction is discarded: later clocking without a new START gets no ACK and writes nothing. A shorter pause does not disturb the transaction.
- R5: A read of address 0x0C (byte 0x19) is acknowledged while the alert is asserted. The reply byte is the client address shifted left with bit 0 clear, which is 0x98.
- R6: While sending, if the block releases SDA for a 1 but samples SDA low on the SCL rising edge, it stops driving SDA until the next START or STOP. That alert response then counts as failed and leaves the mask unchanged.
- R7: A complete alert response sets the mask, which releases the alert, only if the status register is zero at that moment. The mask is bit 7 of offset 0x03, and it can be read and written there.
- R8: In interrupt mode with the mask clear, an event pulse sets the matching status bit and asserts alert_o from the next clock. In comparator or tachometer mode, alert_o stays low.
- R9: The block does not acknowledge the Alert Response Address when int_mode_i is low, or when the alert is not asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Clock-enable tick for the inactivity counter |
| scl_i | input | 1 | SMBus clock as seen on the pin |
| sda_i | input | 1 | SMBus data as seen on the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| int_mode_i | input | 1 | 1: alert pin used as an interrupt; 0: comparator or tachometer use |
| evt_i | input | STAT_W | Event pulses, one per status bit |
| alert_o | output | 1 | 1 requests the alert pin to be pulled low |
| reg_wr_valid_o | output | 1 | One-cycle write strobe to the register file |
| reg_wr_addr_o | output | 8 | Write offset |
| reg_wr_data_o | output | 8 | Write data |
| reg_rd_valid_o | output | 1 | One-cycle read strobe to the register file |
| reg_rd_addr_o | output | 8 | Read offset |
| reg_rd_data_i | input | 8 | Read data, valid combinationally while reg_rd_valid_o is high |

The register port has no ready signal. Without clock stretching the bus cannot be held, so the register file must accept every write strobe and must return read data in the same cycle as the read strobe. Offsets 0x02 and 0x03 are served internally and never appear on the port.

## Verification
SCL and SDA pass through two sampling flops and an edge register. An ACK or data bit therefore appears on sda_oe_o about three clocks after the SCL falling edge that starts its slot. The bench samples SDA in the middle of the following SCL high phase, about twenty clocks after that edge. alert_o follows an event one clock later, and the bench reads it at the next falling clock edge. The mask decision comes about four clocks after the SCL falling edge that ends the reply byte, so the bench checks the alert only after the STOP. Write strobes are counted by a monitor on every rising edge and compared once the transaction has closed.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_RX,
    ST_TX,
    ST_MACK,
    ST_IGNORE
  } smb_state_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 7;

  typedef logic [BYTE_W-1:0] smb_byte_t;
  typedef logic [ADDR_W-1:0] smb_addr_t;

endpackage

// File: rtl/smb_bus_mon.sv
module smb_bus_mon #(
  parameter int unsigned TIMEOUT_TICKS = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic timeout_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_TICKS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(TIMEOUT_TICKS);

  logic [2:0] scl_sh, sda_sh;
  logic       activity;
  logic [CNT_W-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
    end
  end

  assign sda_o      = sda_sh[1];
  assign scl_rise_o = scl_sh[1] & ~scl_sh[2];
  assign scl_fall_o = ~scl_sh[1] & scl_sh[2];
  assign start_o    = scl_sh[1] & scl_sh[2] & sda_sh[2] & ~sda_sh[1];
  assign stop_o     = scl_sh[1] & scl_sh[2] & ~sda_sh[2] & sda_sh[1];
  assign activity   = (scl_sh[1] ^ scl_sh[2]) | (sda_sh[1] ^ sda_sh[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
    end else if (activity) begin
      idle_cnt <= '0;
    end else if (tick_i && idle_cnt != CNT_FULL) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign timeout_o = tick_i & ~activity & (idle_cnt == CNT_LAST);

  p_quiet_after_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> !timeout_o)
    else $error("timeout right after bus activity");

endmodule

// File: rtl/smb_client_fsm.sv
module smb_client_fsm
  import smb_alert_pkg::*;
#(
  parameter smb_addr_t CLIENT_ADDR = 7'h4C,
  parameter smb_addr_t ARA_ADDR    = 7'h0C
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sda_i,
  input  logic      scl_rise_i,
  input  logic      scl_fall_i,
  input  logic      start_i,
  input  logic      stop_i,
  input  logic      timeout_i,
  input  logic      ara_en_i,
  input  smb_byte_t rd_data_i,
  output logic      sda_oe_o,
  output logic      wr_valid_o,
  output smb_byte_t wr_addr_o,
  output smb_byte_t wr_data_o,
  output logic      rd_valid_o,
  output smb_byte_t rd_addr_o,
  output logic      ara_done_o
);
  localparam smb_byte_t ARA_REPLY = {CLIENT_ADDR, 1'b0};

  smb_state_e state_q;
  logic [3:0] cnt_q;
  smb_byte_t  shreg_q, ptr_q, wr_addr_q, wr_data_q, tx_byte;
  logic [1:0] byteidx_q;
  logic       nxt_tx_q, is_ara_q, oe_q, wr_valid_q, ara_done_q;
  logic       bus_evt, load_tx, addr_client, addr_ara;

  assign bus_evt     = timeout_i | start_i | stop_i;
  assign addr_client = shreg_q[7:1] == CLIENT_ADDR;
  assign addr_ara    = (shreg_q[7:1] == ARA_ADDR) & shreg_q[0] & ara_en_i;
  assign load_tx     = ~bus_evt & scl_fall_i &
                       (((state_q == ST_ACK) & nxt_tx_q) | (state_q == ST_MACK));
  assign tx_byte     = is_ara_q ? ARA_REPLY : rd_data_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      shreg_q    <= '0;
      ptr_q      <= '0;
      byteidx_q  <= '0;
      nxt_tx_q   <= 1'b0;
      is_ara_q   <= 1'b0;
      oe_q       <= 1'b0;
      wr_valid_q <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      ara_done_q <= 1'b0;
    end else begin
      wr_valid_q <= 1'b0;
      ara_done_q <= 1'b0;
      if (timeout_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else if (start_i) begin
        state_q   <= ST_ADDR;
        cnt_q     <= '0;
        oe_q      <= 1'b0;
        byteidx_q <= '0;
        is_ara_q  <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              shreg_q <= {shreg_q[6:0], sda_i};
              cnt_q   <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              if (addr_client) begin
                state_q  <= ST_ACK;
                oe_q     <= 1'b1;
                nxt_tx_q <= shreg_q[0];
                is_ara_q <= 1'b0;
              end else if (addr_ara) begin
                state_q  <= ST_ACK;
                oe_q     <= 1'b1;
                nxt_tx_q <= 1'b1;
                is_ara_q <= 1'b1;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (nxt_tx_q) begin
                shreg_q <= tx_byte;
                oe_q    <= ~tx_byte[7];
                state_q <= ST_TX;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (scl_rise_i) begin
              shreg_q <= {shreg_q[6:0], sda_i};
              cnt_q   <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              if (byteidx_q == 2'd2) begin
                state_q <= ST_IGNORE;
              end else begin
                if (byteidx_q == 2'd0) begin
                  ptr_q <= shreg_q;
                end else begin
                  wr_valid_q <= 1'b1;
                  wr_addr_q  <= ptr_q;
                  wr_data_q  <= shreg_q;
                end
                byteidx_q <= byteidx_q + 2'd1;
                state_q   <= ST_ACK;
                oe_q      <= 1'b1;
                nxt_tx_q  <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 4'd1;
              if (!oe_q && !sda_i) begin
                state_q <= ST_IGNORE;
              end
            end else if (scl_fall_i) begin
              if (cnt_q == 4'd8) begin
                oe_q       <= 1'b0;
                state_q    <= ST_MACK;
                ara_done_q <= is_ara_q;
              end else begin
                shreg_q <= {shreg_q[6:0], 1'b0};
                oe_q    <= ~shreg_q[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i && sda_i) begin
              state_q <= ST_IGNORE;
            end else if (load_tx) begin
              cnt_q   <= '0;
              shreg_q <= tx_byte;
              oe_q    <= ~tx_byte[7];
              state_q <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign wr_valid_o = wr_valid_q;
  assign wr_addr_o  = wr_addr_q;
  assign wr_data_o  = wr_data_q;
  assign rd_valid_o = load_tx & ~is_ara_q;
  assign rd_addr_o  = ptr_q;
  assign ara_done_o = ara_done_q;

  p_timeout_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_i |=> (state_q == ST_IDLE) && !oe_q)
    else $error("engine not idle after timeout");

  p_ignore_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> !oe_q)
    else $error("SDA driven while ignoring the bus");

  p_wr_after_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_q |-> $past(state_q) == ST_RX)
    else $error("write strobe outside a received data byte");

endmodule

// File: rtl/smb_alert_ctrl.sv
module smb_alert_ctrl #(
  parameter int unsigned STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_mode_i,
  input  logic [STAT_W-1:0] evt_i,
  input  logic              stat_clr_i,
  input  logic              ara_done_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_mask_i,
  output logic [STAT_W-1:0] status_o,
  output logic              mask_o,
  output logic              alert_o
);
  logic [STAT_W-1:0] status_q;
  logic              mask_q, pend_q, ara_mask;

  assign ara_mask = ara_done_i & (status_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      status_q <= (stat_clr_i ? '0 : status_q) | evt_i;
      if (cfg_wr_i) begin
        mask_q <= cfg_mask_i;
      end else if (ara_mask) begin
        mask_q <= 1'b1;
      end
      if (evt_i != '0) begin
        pend_q <= 1'b1;
      end else if (ara_mask && !cfg_wr_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign alert_o  = int_mode_i & pend_q & ~mask_q;

  p_status_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr_i && (evt_i == '0) |=> status_q == '0)
    else $error("status not cleared by read");

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ara_done_i && !cfg_wr_i && (status_q != '0) |=> mask_q == $past(mask_q))
    else $error("mask changed while status pending");

  p_alert_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ara_done_i && !cfg_wr_i && (status_q == '0) |=> !alert_o)
    else $error("alert still asserted after clean response");

endmodule

// File: rtl/smb_alert_client.sv
module smb_alert_client
  import smb_alert_pkg::*;
#(
  parameter smb_addr_t   CLIENT_ADDR   = 7'h4C,
  parameter smb_addr_t   ARA_ADDR      = 7'h0C,
  parameter int unsigned TIMEOUT_TICKS = 25,
  parameter smb_byte_t   STATUS_OFF    = 8'h02,
  parameter smb_byte_t   CFG_OFF       = 8'h03,
  parameter int unsigned STAT_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              int_mode_i,
  input  logic [STAT_W-1:0] evt_i,
  output logic              alert_o,
  output logic              reg_wr_valid_o,
  output logic [7:0]        reg_wr_addr_o,
  output logic [7:0]        reg_wr_data_o,
  output logic              reg_rd_valid_o,
  output logic [7:0]        reg_rd_addr_o,
  input  logic [7:0]        reg_rd_data_i
);
  logic sda_s, scl_rise, scl_fall, start, stop, timeout;
  logic fsm_wr_valid, fsm_rd_valid, ara_done, alert;
  smb_byte_t fsm_wr_addr, fsm_wr_data, fsm_rd_addr, fsm_rd_data, stat_byte;
  logic [STAT_W-1:0] status;
  logic mask, rd_hit_stat, rd_hit_cfg, wr_hit_cfg, wr_hit_stat;

  smb_bus_mon #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_mon (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop), .timeout_o(timeout)
  );

  smb_client_fsm #(.CLIENT_ADDR(CLIENT_ADDR), .ARA_ADDR(ARA_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_i(sda_s), .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop), .timeout_i(timeout),
    .ara_en_i(alert), .rd_data_i(fsm_rd_data), .sda_oe_o(sda_oe_o),
    .wr_valid_o(fsm_wr_valid), .wr_addr_o(fsm_wr_addr), .wr_data_o(fsm_wr_data),
    .rd_valid_o(fsm_rd_valid), .rd_addr_o(fsm_rd_addr), .ara_done_o(ara_done)
  );

  assign rd_hit_stat = fsm_rd_addr == STATUS_OFF;
  assign rd_hit_cfg  = fsm_rd_addr == CFG_OFF;
  assign wr_hit_stat = fsm_wr_addr == STATUS_OFF;
  assign wr_hit_cfg  = fsm_wr_addr == CFG_OFF;

  smb_alert_ctrl #(.STAT_W(STAT_W)) u_alert (
    .clk(clk), .rst_n(rst_n), .int_mode_i(int_mode_i), .evt_i(evt_i),
    .stat_clr_i(fsm_rd_valid & rd_hit_stat), .ara_done_i(ara_done),
    .cfg_wr_i(fsm_wr_valid & wr_hit_cfg), .cfg_mask_i(fsm_wr_data[7]),
    .status_o(status), .mask_o(mask), .alert_o(alert)
  );

  always_comb begin
    stat_byte = '0;
    stat_byte[STAT_W-1:0] = status;
  end

  assign fsm_rd_data    = rd_hit_stat ? stat_byte :
                          rd_hit_cfg  ? {mask, 7'b0} : reg_rd_data_i;
  assign reg_rd_valid_o = fsm_rd_valid & ~rd_hit_stat & ~rd_hit_cfg;
  assign reg_rd_addr_o  = fsm_rd_addr;
  assign reg_wr_valid_o = fsm_wr_valid & ~wr_hit_cfg & ~wr_hit_stat;
  assign reg_wr_addr_o  = fsm_wr_addr;
  assign reg_wr_data_o  = fsm_wr_data;
  assign alert_o        = alert;

endmodule

// File: tb/smb_alert_client_test.sv
module smb_alert_client_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, other_low = 1'b0;
  logic int_mode = 1'b1;
  logic [7:0] evt = '0;
  logic sda_oe, alert, wr_v, rd_v;
  logic [7:0] wr_a, wr_d, rd_a, rd_d;
  logic sda_line;
  logic [7:0] regs [256];
  int n_chk = 0, n_fail = 0, wr_count = 0, tick_div = 0;
  logic [7:0] last_wr_a, last_wr_d;

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe & ~other_low;
  assign rd_d = regs[rd_a];

  smb_alert_client uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .int_mode_i(int_mode), .evt_i(evt), .alert_o(alert),
    .reg_wr_valid_o(wr_v), .reg_wr_addr_o(wr_a), .reg_wr_data_o(wr_d),
    .reg_rd_valid_o(rd_v), .reg_rd_addr_o(rd_a), .reg_rd_data_i(rd_d)
  );

  always @(posedge clk) begin
    tick_div <= (tick_div == 99) ? 0 : tick_div + 1;
    tick <= (tick_div == 99);
    if (wr_v) begin
      wr_count <= wr_count + 1;
      last_wr_a <= wr_a;
      last_wr_d <= wr_d;
      regs[wr_a] <= wr_d;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(4 * Q);
  endtask

  task automatic send_bit(input logic b, input logic pull, output logic s);
    sda_m = b; other_low = pull; w(Q);
    scl_m = 1'b1; w(Q);
    s = sda_line; w(Q);
    scl_m = 1'b0; w(Q);
    other_low = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) send_bit(b[i], 1'b0, s);
    send_bit(1'b1, 1'b0, s);
    ack = ~s;
  endtask

  task automatic read_byte(input logic master_ack, input logic pull7, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      send_bit(1'b1, pull7 && i == 7, s);
      d[i] = s;
    end
    send_bit(~master_ack, 1'b0, s);
  endtask

  task automatic reg_write(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] dat,
                           output logic a0, output logic a1, output logic a2);
    bus_start();
    write_byte({a, 1'b0}, a0);
    write_byte(cmd, a1);
    write_byte(dat, a2);
    bus_stop();
  endtask

  task automatic reg_read(input logic [7:0] cmd, output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start();
    write_byte(8'h98, a0);
    write_byte(cmd, a1);
    bus_start();
    write_byte(8'h99, a2);
    read_byte(1'b0, 1'b0, d);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic ara_read(input logic pull, output logic ack, output logic [7:0] d);
    bus_start();
    write_byte(8'h19, ack);
    if (ack) read_byte(1'b0, pull, d);
    else d = 8'hFF;
    bus_stop();
  endtask

  task automatic pulse_evt(input logic [7:0] v);
    evt = v; w(1); evt = '0; w(1);
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
    check(alert == 1'b0, "R8 reset alert", alert, 0);
    check(wr_count == 0, "R2 reset no strobe", wr_count, 0);
  endtask

  task automatic t_write_read();
    logic a0, a1, a2, ok;
    logic [7:0] d;
    int c0 = wr_count;
    reg_write(7'h4C, 8'h10, 8'hA5, a0, a1, a2);
    check(a0 && a1 && a2, "R1 client address acked", {a0, a1, a2}, 3'b111);
    check(wr_count == c0 + 1 && last_wr_a == 8'h10 && last_wr_d == 8'hA5,
          "R2 write strobe", {last_wr_a, last_wr_d}, 16'h10A5);
    reg_write(7'h4C, 8'h21, 8'h3C, a0, a1, a2);
    check(wr_count == c0 + 2 && last_wr_d == 8'h3C, "R2 second write", last_wr_d, 8'h3C);
    reg_read(8'h10, d, ok);
    check(ok && d == 8'hA5, "R3 read back 0x10", d, 8'hA5);
    reg_read(8'h21, d, ok);
    check(ok && d == 8'h3C, "R3 read back 0x21", d, 8'h3C);
  endtask

  task automatic t_bad_addr();
    logic a0, a1, a2, ok;
    logic [7:0] d;
    int c0 = wr_count;
    reg_write(7'h4D, 8'h10, 8'hEE, a0, a1, a2);
    check(!a0 && !a1 && !a2, "R1 foreign address not acked", {a0, a1, a2}, 0);
    check(wr_count == c0, "R1 foreign address no strobe", wr_count - c0, 0);
    reg_read(8'h10, d, ok);
    check(d == 8'hA5, "R1 register untouched", d, 8'hA5);
  endtask

  task automatic t_extra_byte();
    logic a0, a1, a2, a3, ok;
    logic [7:0] d;
    int c0 = wr_count;
    bus_start();
    write_byte(8'h98, a0);
    write_byte(8'h11, a1);
    write_byte(8'h77, a2);
    write_byte(8'h66, a3);
    bus_stop();
    check(a2 && !a3, "R2 extra byte nacked", {a2, a3}, 2'b10);
    check(wr_count == c0 + 1, "R2 one strobe only", wr_count - c0, 1);
    reg_read(8'h11, d, ok);
    check(d == 8'h77, "R2 extra byte not written", d, 8'h77);
  endtask

  task automatic t_timeout();
    logic a0, a1, a2;
    int c0 = wr_count;
    bus_start();
    write_byte(8'h98, a0);
    write_byte(8'h13, a1);
    w(1000);
    write_byte(8'h44, a2);
    bus_stop();
    check(a2 && wr_count == c0 + 1 && last_wr_d == 8'h44, "R4 short pause kept",
          last_wr_d, 8'h44);
    c0 = wr_count;
    bus_start();
    write_byte(8'h98, a0);
    write_byte(8'h12, a1);
    w(3000);
    write_byte(8'h55, a2);
    bus_stop();
    check(a1 && !a2, "R4 data after timeout not acked", a2, 0);
    check(wr_count == c0, "R4 partial write dropped", wr_count - c0, 0);
  endtask

  task automatic t_alert_ara();
    logic ack, ok, a0, a1, a2;
    logic [7:0] d;
    int_mode = 1'b1;
    pulse_evt(8'h04);
    check(alert == 1'b1, "R8 alert on event", alert, 1);
    ara_read(1'b0, ack, d);
    check(ack && d == 8'h98, "R5 alert response reply", d, 8'h98);
    check(alert == 1'b1, "R7 no mask while status set", alert, 1);
    reg_read(8'h02, d, ok);
    check(ok && d == 8'h04, "R3 status read", d, 8'h04);
    reg_read(8'h02, d, ok);
    check(d == 8'h00, "R3 status cleared by read", d, 0);
    check(alert == 1'b1, "R7 alert held after status read", alert, 1);
    ara_read(1'b0, ack, d);
    check(ack && d == 8'h98, "R5 second reply", d, 8'h98);
    check(alert == 1'b0, "R7 alert released", alert, 0);
    reg_read(8'h03, d, ok);
    check(d == 8'h80, "R7 mask readable", d, 8'h80);
    ara_read(1'b0, ack, d);
    check(!ack, "R9 no reply when alert idle", ack, 0);
    reg_write(7'h4C, 8'h03, 8'h00, a0, a1, a2);
    reg_read(8'h03, d, ok);
    check(d == 8'h00 && alert == 1'b0, "R7 mask written clear", d, 0);
    pulse_evt(8'h01);
    check(alert == 1'b1, "R8 alert after unmask", alert, 1);
  endtask

  task automatic t_comp_mode();
    logic ack;
    logic [7:0] d;
    int_mode = 1'b0; w(1);
    check(alert == 1'b0, "R8 alert low in comparator mode", alert, 0);
    ara_read(1'b0, ack, d);
    check(!ack, "R9 no reply in comparator mode", ack, 0);
    int_mode = 1'b1; w(1);
    check(alert == 1'b1, "R8 alert back in interrupt mode", alert, 1);
  endtask

  task automatic t_arbitration();
    logic ack, ok;
    logic [7:0] d;
    reg_read(8'h02, d, ok);
    ara_read(1'b1, ack, d);
    check(ack && d == 8'h7F, "R6 lost arbitration releases SDA", d, 8'h7F);
    check(alert == 1'b1, "R6 lost reply leaves mask", alert, 1);
    ara_read(1'b0, ack, d);
    check(ack && d == 8'h98 && alert == 1'b0, "R7 clean retry masks", {d, alert}, 9'h130);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) regs[i] = '0;
    w(5);
    rst_n = 1'b1;
    w(5);
    t_reset();
    t_write_read();
    t_bad_addr();
    t_extra_byte();
    t_timeout();
    t_alert_ara();
    t_comp_mode();
    t_arbitration();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule